// File: doc/BRIEF.md
# Modem Status Register Logic

This block holds the modem status byte of a 16550-class serial port. It watches four active-low modem lines (clear to send, data set ready, ring indicate, data carrier detect). Each line passes through a synchronizer and an edge detector. The block keeps one live status bit and one sticky change flag per line. It raises a modem-status interrupt request while any change flag is set and the interrupt is enabled.

In loopback the live status bits come from four modem-control outputs (request to send, data terminal ready, and the two general-purpose outputs) instead of the pins. The change detectors run on those looped-back levels, so software can set the flags by toggling its own control bits. A one-cycle read strobe returns the byte. The same strobe clears the change flags on the next clock edge. A change that is detected on the same edge is kept.

Top module: `uart_modem_status`

## Requirements
- R1: Flag bit 0 sets when the clear-to-send line level changes in either direction. A pin change shows in flag bit 0 after the third rising clock edge.
- R2: Flag bit 1 sets on any change of the data-set-ready line. Flag bit 3 sets on any change of the carrier-detect line.
- R3: Flag bit 2 sets only when the ring-indicate pin goes from 0 to 1, which is when status bit 6 falls. A 1-to-0 pin transition leaves flag bit 2 unchanged.
- R4: With loopback off, status bits 4, 5, 6 and 7 are the inverted levels of modem_n_in[0] (CTS), [1] (DSR), [2] (RI) and [3] (DCD). They update two clock edges after the pin changes.
- R5: With loopback on, status bits 4 to 7 follow loop_src[0] (RTS), [1] (DTR), [2] (OUT1) and [3] (OUT2) in the same cycle. The pins then have no effect on the byte.
- R6: In loopback, the change detectors run on the loop_src levels. A rising or falling RTS sets flag 0, and a falling OUT1 sets flag 2.
- R7: rd_data shows {status[7:4], flags[3:0]} in the cycle of rd_stb. A read clears the flags at the following edge, except any flag whose event is detected on that same edge.
- R8: A set flag stays set until a read strobe, whatever the lines do meanwhile.
- R9: ms_irq is 1 exactly when ms_irq_en is 1 and at least one flag is set.
- R10: Reset clears all flags. The first line levels seen after reset are taken as the reference, so no flag sets until a line actually changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| modem_n_in | input | 4 | Active-low pins: [0] CTS, [1] DSR, [2] RI, [3] DCD |
| loop_en | input | 1 | Loopback select |
| loop_src | input | 4 | Control outputs for loopback: [0] RTS, [1] DTR, [2] OUT1, [3] OUT2 |
| rd_stb | input | 1 | Register read strobe (clears flags) |
| ms_irq_en | input | 1 | Modem-status interrupt enable |
| rd_data | output | 8 | Status byte: [7:4] line levels, [3:0] change flags |
| ms_irq | output | 1 | Modem-status interrupt request |

## Verification
The lines are driven one at a time, in both directions. This tells the any-change detectors apart from the trailing-edge ring detector, and it pins down the two-edge status latency and the three-edge flag latency. Loopback is tried twice: once with the pins toggling, which must leave the byte alone, and once with the control bits toggling, which must set the flags. A read strobe is placed on the same edge as a new event, so the bench can tell whether that event survives the clear. The interrupt enable is switched while flags are set, which separates the gating from the flag state.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int LINES    = 4;
  localparam int IDX_CTS  = 0;
  localparam int IDX_DSR  = 1;
  localparam int IDX_RI   = 2;
  localparam int IDX_DCD  = 3;

  // Event for one line: ring uses falling active-high level, others any change
  function automatic logic line_event(input logic prev_lvl, input logic cur_lvl,
                                      input logic falling_only);
    if (falling_only) return prev_lvl & ~cur_lvl;
    return prev_lvl ^ cur_lvl;
  endfunction

  function automatic logic [7:0] pack_status(input logic [LINES-1:0] lvl,
                                             input logic [LINES-1:0] flg);
    return {lvl, flg};
  endfunction
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        stage_q[s] <= '1;
      else if (s == 0)
        stage_q[s] <= d;
      else
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/msr_change_det.sv
module msr_change_det
  import msr_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter int RING_IDX  = 2,
  parameter int ARM_DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] evt,
  output logic             armed
);
  logic [ARM_DEPTH-1:0] arm_q;
  logic [WIDTH-1:0]     prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= '0;
      prev_q <= '0;
    end else begin
      arm_q  <= {arm_q[ARM_DEPTH-2:0], 1'b1};
      prev_q <= lvl;
    end
  end

  assign armed = arm_q[ARM_DEPTH-1];

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    localparam bit FALL_ONLY = (i == RING_IDX);
    assign evt[i] = armed & line_event(prev_q[i], lvl[i], FALL_ONLY);
  end
endmodule

// File: rtl/msr_flags.sv
module msr_flags #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] evt,
  input  logic             clr,
  output logic [WIDTH-1:0] flags
);
  logic [WIDTH-1:0] flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (clr ? '0 : flags_q) | evt;
  end

  assign flags = flags_q;

  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && evt == '0) |=> flags_q == '0);

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (flags_q & $past(flags_q)) == $past(flags_q));
endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] modem_n_in,
  input  logic             loop_en,
  input  logic [LINES-1:0] loop_src,
  input  logic             rd_stb,
  input  logic             ms_irq_en,
  output logic [7:0]       rd_data,
  output logic             ms_irq
);
  localparam int ARM_DEPTH = SYNC_STAGES + 1;

  logic [LINES-1:0] pin_sync;
  logic [LINES-1:0] line_lvl;
  logic [LINES-1:0] line_evt;
  logic [LINES-1:0] delta_q;
  logic             det_armed;

  msr_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(modem_n_in), .q(pin_sync));

  assign line_lvl = loop_en ? loop_src : ~pin_sync;

  msr_change_det #(.WIDTH(LINES), .RING_IDX(IDX_RI), .ARM_DEPTH(ARM_DEPTH)) u_det (
    .clk(clk), .rst_n(rst_n), .lvl(line_lvl), .evt(line_evt), .armed(det_armed));

  msr_flags #(.WIDTH(LINES)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(line_evt), .clr(rd_stb), .flags(delta_q));

  assign rd_data = pack_status(line_lvl, delta_q);
  assign ms_irq  = ms_irq_en & (|delta_q);

  // R1
  dcts_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(delta_q[IDX_CTS]) |-> $past(line_lvl[IDX_CTS]) != $past(line_lvl[IDX_CTS], 2));

  // R3
  teri_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(delta_q[IDX_RI]) |-> (!$past(line_lvl[IDX_RI]) && $past(line_lvl[IDX_RI], 2)));

  // R10
  quiet_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !det_armed |=> delta_q == '0);
endmodule

// File: tb/tb_uart_modem_status.sv
module tb_uart_modem_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pins = 4'b0101;
  logic       loop_en = 1'b0;
  logic [3:0] mcr = 4'b0000;
  logic       rd_stb = 1'b0;
  logic       irq_en = 1'b1;
  logic [7:0] rd_data;
  logic       ms_irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_modem_status dut (
    .clk(clk), .rst_n(rst_n), .modem_n_in(pins), .loop_en(loop_en),
    .loop_src(mcr), .rd_stb(rd_stb), .ms_irq_en(irq_en),
    .rd_data(rd_data), .ms_irq(ms_irq));

  // Behavioural reference: queue of pin samples, previous levels, flags
  logic [3:0] pin_q[$];
  logic [3:0] m_prev = '0;
  logic [3:0] m_flags = '0;
  int         m_edges = 0;

  function automatic logic [3:0] model_level();
    if (loop_en) return mcr;
    return ~pin_q[0];
  endfunction

  initial begin
    pin_q.push_back(4'hF);
    pin_q.push_back(4'hF);
  end

  always @(posedge clk) begin
    logic [3:0] cur;
    logic [3:0] ev;
    if (!rst_n) begin
      pin_q = '{4'hF, 4'hF};
      m_prev = '0; m_flags = '0; m_edges = 0;
    end else begin
      cur = model_level();
      ev = '0;
      if (m_edges >= 3)
        for (int i = 0; i < 4; i++)
          ev[i] = (i == 2) ? (m_prev[i] && !cur[i]) : (m_prev[i] != cur[i]);
      m_flags = (rd_stb ? 4'h0 : m_flags) | ev;
      m_prev = cur;
      if (m_edges < 3) m_edges++;
      void'(pin_q.pop_front());
      pin_q.push_back(pins);
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison with the model (covers R1 R2 R3 R4 R5 R6 R7 R8 R9 R10)
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      check("model rd_data R4 R7", rd_data, {model_level(), m_flags});
      check("model ms_irq R9", {7'd0, ms_irq}, {7'd0, irq_en & (|m_flags)});
    end
  end

  task automatic tick(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic peek(string tag, logic [7:0] exp);
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic read_pulse();
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(6);
    peek("R10 reset quiet, R4 levels", 8'hA0);
    check("R9 no irq after reset", {7'd0, ms_irq}, 8'd0);

    // CTS pin 1 -> 0
    pins = 4'b0100;
    tick(2); peek("R4 status after two edges", 8'hB0);
    tick(1); peek("R1 cts delta", 8'hB1);
    check("R9 irq with flag", {7'd0, ms_irq}, 8'd1);

    @(negedge clk); rd_stb = 1'b1; peek("R7 read value", 8'hB1);
    @(negedge clk); rd_stb = 1'b0; peek("R7 cleared after read", 8'hB0);

    pins = 4'b0110;
    tick(3); peek("R2 dsr delta", 8'h92);
    tick(5); peek("R8 flag sticky", 8'h92);

    pins = 4'b1110;
    tick(3); peek("R2 dcd delta", 8'h1A);
    read_pulse(); peek("R7 clear", 8'h10);

    pins = 4'b1010;
    tick(3); peek("R3 ri falling pin no flag", 8'h50);
    pins = 4'b1110;
    tick(3); peek("R3 ri trailing edge flag", 8'h14);

    irq_en = 1'b0; #1;
    check("R9 irq gated off", {7'd0, ms_irq}, 8'd0);
    tick(1); irq_en = 1'b1; #1;
    check("R9 irq gated on", {7'd0, ms_irq}, 8'd1);
    read_pulse();

    // Loopback
    @(negedge clk); mcr = 4'b0000; loop_en = 1'b1;
    peek("R5 loop status immediate", 8'h00);
    tick(2); read_pulse(); peek("R5 cleared in loop", 8'h00);
    pins = 4'b0001;
    tick(4); peek("R5 pins ignored in loop", 8'h00);

    @(negedge clk); mcr = 4'b0001; peek("R5 rts to bit4", 8'h10);
    tick(1); peek("R6 rts delta", 8'h11);
    read_pulse();
    @(negedge clk); mcr = 4'b0101;
    tick(1); peek("R6 out1 rise no flag", 8'h50);
    @(negedge clk); mcr = 4'b0001;
    tick(1); peek("R6 out1 fall flag", 8'h14);

    @(negedge clk); mcr = 4'b0011; rd_stb = 1'b1;
    peek("R7 read same edge as event", 8'h34);
    @(negedge clk); rd_stb = 1'b0;
    peek("R7 event kept over clear", 8'h32);

    @(negedge clk); loop_en = 1'b0;
    tick(6);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #100000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule